// File: doc/BRIEF.md
# Calendar Month Length and Day-of-Year Unit

This unit takes a calendar date given as a binary month number, a binary day-of-month and a flag that marks the current year as a leap year. It returns two results. The first is the length of the month as four mutually exclusive lines, one each for 28, 29, 30 and 31 days. The second is the ordinal day of the year, from 1 to 366.

The day of the year comes from one adder. It adds the day number to a starting offset for the month. The leap flag is already folded into that offset, so no second correction is needed. Dates that cannot exist are flagged. These are a month code outside 1..12, day zero, or a day past the end of the selected month. For such dates the day-of-year result reads zero.

A parameter chooses between two output modes: one register stage, or purely combinational outputs.

Top module: `cal_day_unit`

## Requirements
- R1: `len_oh_o` encodes the month length one-hot, with bit 0 = 28, bit 1 = 29, bit 2 = 30 and bit 3 = 31 days. Months 4, 6, 9 and 11 set bit 2. Months 1, 3, 5, 7, 8, 10 and 12 set bit 3.
- R2: For month 2, bit 1 is set when `leap_i` is 1 and bit 0 is set when it is 0. For every other month, `leap_i` does not change `len_oh_o`.
- R3: For month codes 0 and 13..15, `len_oh_o` is 0000, `invalid_o` is 1 and `doy_o` is 0.
- R4: For a valid date, `doy_o` equals the day number plus the count of days in all earlier months of the year. February counts as 29 days when `leap_i` is 1, so leap adds one only for months 3 and later.
- R5: `invalid_o` is 1 and `doy_o` is 0 when the day is 0 or the day exceeds the month length given by R1/R2.
- R6: `doy_o` never exceeds 366. December 31 gives 366 with `leap_i`=1 and 365 without it.
- R7: With `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising edge of `clk_i`. While `rst_ni` is low, the outputs are `len_oh_o`=0, `doy_o`=0 and `invalid_o`=1.
- R8: For any valid month code, exactly one bit of `len_oh_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; used only when outputs are registered |
| rst_ni | input | 1 | Asynchronous active-low reset |
| month_i | input | 4 | Month number, 1 = first month, 12 = last |
| day_i | input | 5 | Day of month, 1..31 |
| leap_i | input | 1 | Current year is a leap year |
| len_oh_o | output | 4 | One-hot month length (28/29/30/31) |
| doy_o | output | 9 | Ordinal day of year, 0 when invalid |
| invalid_o | output | 1 | Date does not exist |

## Verification
A wrong offset term shows up at the ports as a day-of-year value that is shifted by a fixed amount for every day of one month. Each offset is computed from the months before it, so the error also carries into every later month. A leap term applied to the wrong months separates the leap and common results before March, or from March on. Since the unit holds no state beyond the optional output stage, any fault shows up one cycle after the offending input is applied. The bench therefore sweeps every month, day and leap combination and compares each result at that cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned MONTH_W = 4;
  localparam int unsigned DAY_W   = 5;
  localparam int unsigned DOY_W   = 9;
  localparam int unsigned LEN_N   = 4;
  localparam int unsigned N_MONTH = 12;

  // index of each line in the one-hot length vector
  typedef enum logic [1:0] {
    LEN_28 = 2'd0,
    LEN_29 = 2'd1,
    LEN_30 = 2'd2,
    LEN_31 = 2'd3
  } len_idx_e;

  // length of month m in a common year
  function automatic int unsigned common_len(input int unsigned m);
    if (m == 2) return 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
#(
  parameter int unsigned MW = MONTH_W,
  parameter int unsigned NM = N_MONTH
) (
  input  logic [MW-1:0]    month_i,
  input  logic             leap_i,
  output logic [LEN_N-1:0] len_oh_o,
  output logic             month_ok_o
);
  always_comb begin
    month_ok_o = (month_i != '0) && (int'(month_i) <= NM);
    len_oh_o   = '0;
    if (month_ok_o) begin
      unique case (common_len(int'(month_i)))
        28:      len_oh_o[leap_i ? LEN_29 : LEN_28] = 1'b1;
        30:      len_oh_o[LEN_30] = 1'b1;
        default: len_oh_o[LEN_31] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cal_month_offset.sv
module cal_month_offset
  import cal_pkg::*;
#(
  parameter int unsigned MW = MONTH_W,
  parameter int unsigned OW = DOY_W,
  parameter int unsigned NM = N_MONTH
) (
  input  logic [MW-1:0] month_i,
  input  logic          leap_i,
  output logic [OW-1:0] offset_o
);
  // running sum of earlier months, leap folded in after February
  always_comb begin
    offset_o = '0;
    for (int k = 1; k < NM; k++) begin
      if (int'(month_i) > k) offset_o = offset_o + OW'(common_len(k));
    end
    if (leap_i && int'(month_i) > 2) offset_o = offset_o + OW'(1);
  end
endmodule

// File: rtl/cal_day_check.sv
module cal_day_check
  import cal_pkg::*;
#(
  parameter int unsigned DW = DAY_W,
  parameter int unsigned OW = DOY_W
) (
  input  logic [DW-1:0]    day_i,
  input  logic [LEN_N-1:0] len_oh_i,
  input  logic             month_ok_i,
  input  logic [OW-1:0]    offset_i,
  output logic [OW-1:0]    doy_o,
  output logic             invalid_o
);
  logic [DW-1:0] day_max;

  always_comb begin
    day_max = '0;
    for (int i = 0; i < LEN_N; i++) begin
      if (len_oh_i[i]) day_max = DW'(28 + i);
    end
  end

  always_comb begin
    invalid_o = !month_ok_i || (day_i == '0) || (day_i > day_max);
    doy_o     = invalid_o ? '0 : offset_i + OW'(day_i);
  end
endmodule

// File: rtl/cal_day_unit.sv
module cal_day_unit
  import cal_pkg::*;
#(
  parameter int unsigned MW      = MONTH_W,
  parameter int unsigned DW      = DAY_W,
  parameter int unsigned OW      = DOY_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MW-1:0]    month_i,
  input  logic [DW-1:0]    day_i,
  input  logic             leap_i,
  output logic [LEN_N-1:0] len_oh_o,
  output logic [OW-1:0]    doy_o,
  output logic             invalid_o
);
  logic [LEN_N-1:0] len_c;
  logic             month_ok_c;
  logic [OW-1:0]    offset_c;
  logic [OW-1:0]    doy_c;
  logic             inv_c;

  cal_month_len #(.MW(MW)) u_len (
    .month_i   (month_i),
    .leap_i    (leap_i),
    .len_oh_o  (len_c),
    .month_ok_o(month_ok_c)
  );

  cal_month_offset #(.MW(MW), .OW(OW)) u_off (
    .month_i (month_i),
    .leap_i  (leap_i),
    .offset_o(offset_c)
  );

  cal_day_check #(.DW(DW), .OW(OW)) u_chk (
    .day_i     (day_i),
    .len_oh_i  (len_c),
    .month_ok_i(month_ok_c),
    .offset_i  (offset_c),
    .doy_o     (doy_c),
    .invalid_o (inv_c)
  );

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          len_oh_o  <= '0;
          doy_o     <= '0;
          invalid_o <= 1'b1;
        end else begin
          len_oh_o  <= len_c;
          doy_o     <= doy_c;
          invalid_o <= inv_c;
        end
      end

      p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok_q && $stable(month_i) && $stable(day_i) && $stable(leap_i))
        |=> ($stable(doy_o) && $stable(invalid_o) && $stable(len_oh_o)));
    end else begin : g_comb
      assign len_oh_o  = len_c;
      assign doy_o     = doy_c;
      assign invalid_o = inv_c;
    end
  endgenerate

  p_len_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    month_ok_c |-> ($countones(len_c) == 1));

  p_bad_month_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !month_ok_c |-> (len_c == '0 && inv_c && doy_c == '0));

  p_feb_leap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_c[LEN_29] |-> (leap_i && month_i == MW'(2)));

  p_inv_doy_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (doy_o == '0));

  p_doy_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !invalid_o |-> (doy_o != '0 && doy_o <= OW'(366)));
endmodule

// File: tb/cal_day_unit_test.sv
`timescale 1ns/1ps
module cal_day_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] month = '0;
  logic [4:0] day = '0;
  logic       leap = 1'b0;
  logic [3:0] len_oh;
  logic [8:0] doy;
  logic       inv;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cal_day_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .month_i(month), .day_i(day), .leap_i(leap),
    .len_oh_o(len_oh), .doy_o(doy), .invalid_o(inv)
  );

  function automatic int mlen(input int m, input bit lp);
    if (m < 1 || m > 12) return 0;
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int exp_doy(input int m, input int d, input bit lp);
    int acc;
    if (mlen(m, lp) == 0 || d == 0 || d > mlen(m, lp)) return 0;
    acc = 0;
    for (int k = 1; k < m; k++) acc += mlen(k, lp);
    return acc + d;
  endfunction

  function automatic logic [3:0] exp_len(input int m, input bit lp);
    case (mlen(m, lp))
      28: return 4'b0001;
      29: return 4'b0010;
      30: return 4'b0100;
      31: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (m=%0d d=%0d l=%0d)",
               req, act, exp, month, day, leap);
    end
  endtask

  task automatic apply(input int m, input int d, input bit lp);
    logic [3:0] el;
    int ed;
    bit ei;
    @(negedge clk);
    month = 4'(m); day = 5'(d); leap = lp;
    @(posedge clk);
    #1;
    el = exp_len(m, lp);
    ed = exp_doy(m, d, lp);
    ei = (ed == 0);
    check(len_oh == el, (m < 1 || m > 12) ? "R3" : (m == 2 ? "R2" : "R1"), len_oh, el);
    check(inv == ei, (m < 1 || m > 12) ? "R3" : "R5", inv, ei);
    check(doy == 9'(ed), ei ? "R5" : (ed >= 365 ? "R6" : "R4"), doy, ed);
    if (m >= 1 && m <= 12)
      check($countones(len_oh) == 1, "R8", $countones(len_oh), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd2024;
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    check(len_oh == 4'b0000, "R7", len_oh, 0);
    check(doy == 9'd0, "R7", doy, 0);
    check(inv == 1'b1, "R7", inv, 1);
    @(negedge clk);
    rst_ni = 1'b1;

    // directed corners
    apply(12, 31, 1'b1);   // R6 366
    apply(12, 31, 1'b0);   // R6 365
    apply(2, 29, 1'b0);    // R5
    apply(2, 29, 1'b1);    // R2
    apply(3, 1, 1'b1);     // R4 61
    apply(3, 1, 1'b0);     // R4 60
    apply(0, 5, 1'b0);     // R3
    apply(13, 5, 1'b1);    // R3
    apply(4, 31, 1'b0);    // R5

    // R7 latency: new input not visible before the next edge
    apply(12, 31, 1'b1);
    @(negedge clk);
    month = 4'd1; day = 5'd1; leap = 1'b0;
    #2;
    check(doy == 9'd366, "R7", doy, 366);
    @(posedge clk);
    #1;
    check(doy == 9'd1, "R7", doy, 1);

    // exhaustive sweep
    for (int lp = 0; lp < 2; lp++)
      for (int m = 0; m < 16; m++)
        for (int d = 0; d < 32; d++)
          apply(m, d, lp[0]);

    // random mix
    void'($urandom(seed));
    for (int i = 0; i < 500; i++)
      apply(int'($urandom % 16), int'($urandom % 32), 1'($urandom));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule